// File: doc/BRIEF.md
# Linear Frequency Sweep Generator

This block produces a frequency tuning word that ramps in a straight line between a programmable floor and ceiling. The rising and falling slopes are configured separately. Each direction has its own step size, added or subtracted per step, and its own dwell interval, which is the number of clock cycles between steps. The block sits ahead of a phase accumulator and replaces its static tuning word while a sweep is running.

When the sweep is disabled, the block passes a static base tuning word through one register stage. Raising the enable loads the floor and starts a rising ramp. From then on a direction input moves the ramp up or down. A step that would cross a limit stops exactly on that limit, and a flag reports that the limit has been reached. The limit, step and rate inputs are captured at the start of a sweep and again at every step boundary. Software can therefore rewrite them at any time without disturbing the interval in progress.

The asynchronous active-low reset is synchronised inside the block before it releases the state registers.

Top module: `lin_sweep_gen`

## Requirements
- R1: While reset is applied, `ftw_out` is 0 and both limit flags are 0.
- R2: While `sweep_en` is 0, `ftw_out` equals the `ftw_base` value sampled one clock earlier and both flags are 0. No limit, step, rate or direction input changes the output.
- R3: On the first clock where `sweep_en` is 1 after being 0, the block does four things: it loads `ftw_out` with `lim_lo`, sets `at_lo`, captures all limit, step and rate inputs, and selects the rising direction. The rising direction holds until `dir_fall` changes.
- R4: While rising, `ftw_out` increases by the captured `step_up` once every `rate_up` cycles and holds its value between steps.
- R5: While falling, `ftw_out` decreases by the captured `step_dn` once every `rate_dn` cycles and holds its value between steps.
- R6: A rising step whose result would exceed the captured upper limit sets `ftw_out` to that limit. This includes a carry out of the word width. `at_hi` is 1 exactly while an active sweep sits on the captured upper limit.
- R7: A falling step whose result would go below the captured lower limit sets `ftw_out` to that limit. This includes a borrow below zero. `at_lo` is 1 exactly while an active sweep sits on the captured lower limit.
- R8: A rate value of 0 behaves like 1: one step on every clock.
- R9: `dir_fall` = 0 selects rising and 1 selects falling. Any change of `dir_fall` during a sweep restarts the dwell count, and no step is taken on that clock. The next step follows a full interval of the newly selected direction.
- R10: New limit, step and rate values are captured only at sweep start and at each step boundary. A step always uses the values captured at the previous boundary. A newly captured rate sets the length of the following interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sweep_en | input | 1 | Sweep enable; 0 passes the base word through |
| dir_fall | input | 1 | Ramp direction: 0 rising, 1 falling |
| ftw_base | input | FW | Static tuning word used while the sweep is off |
| lim_hi | input | FW | Upper sweep limit |
| lim_lo | input | FW | Lower sweep limit and sweep start value |
| step_up | input | FW | Increment per rising step |
| step_dn | input | FW | Decrement per falling step |
| rate_up | input | RW | Cycles between rising steps (0 treated as 1) |
| rate_dn | input | RW | Cycles between falling steps (0 treated as 1) |
| ftw_out | output | FW | Current tuning word |
| at_hi | output | 1 | Sweep is sitting on the upper limit |
| at_lo | output | 1 | Sweep is sitting on the lower limit |

## Verification
The assertions check the following on every cycle:
- the base-word pass-through while disabled;
- the load of the floor at sweep start;
- that the output holds between dwell ticks;
- that the dwell count stays inside the captured interval;
- the counter restart when the direction changes;
- that each raised flag agrees with the captured limit.

Only the bench scenarios can show that step sizes and intervals produce the right value sequence. The same holds for the clamp results when the sum overflows or the difference underflows, and for the rule that configuration written mid-interval changes nothing until the next boundary. For these the bench compares every cycle against an arithmetic model, using an 8-bit word and a 3-bit rate.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  typedef enum logic {
    DIR_RISE = 1'b0,
    DIR_FALL = 1'b1
  } dir_e;
endpackage

// File: rtl/lsg_rst_sync.sv
module lsg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/lsg_cfg_hold.sv
// Captured copy of the sweep configuration; reloads only when load_i is set.
module lsg_cfg_hold #(
  parameter int FW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [FW-1:0] hi_i,
  input  logic [FW-1:0] lo_i,
  input  logic [FW-1:0] up_i,
  input  logic [FW-1:0] dn_i,
  input  logic [RW-1:0] ru_i,
  input  logic [RW-1:0] rd_i,
  output logic [FW-1:0] hi_o,
  output logic [FW-1:0] lo_o,
  output logic [FW-1:0] up_o,
  output logic [FW-1:0] dn_o,
  output logic [RW-1:0] ru_o,
  output logic [RW-1:0] rd_o
);
  localparam int NW = 4;   // number of word-wide fields
  localparam int NR = 2;   // number of rate fields

  logic [NW-1:0][FW-1:0] wrd_q, wrd_d, wrd_in;
  logic [NR-1:0][RW-1:0] rat_q, rat_d, rat_in;

  assign wrd_in = {dn_i, up_i, lo_i, hi_i};
  assign rat_in = {rd_i, ru_i};

  for (genvar gw = 0; gw < NW; gw++) begin : g_wrd
    always_comb wrd_d[gw] = load_i ? wrd_in[gw] : wrd_q[gw];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wrd_q[gw] <= '0;
      else if (load_i) wrd_q[gw] <= wrd_d[gw];
    end
  end

  for (genvar gr = 0; gr < NR; gr++) begin : g_rat
    always_comb rat_d[gr] = load_i ? rat_in[gr] : rat_q[gr];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rat_q[gr] <= '0;
      else if (load_i) rat_q[gr] <= rat_d[gr];
    end
  end

  assign hi_o = wrd_q[0];
  assign lo_o = wrd_q[1];
  assign up_o = wrd_q[2];
  assign dn_o = wrd_q[3];
  assign ru_o = rat_q[0];
  assign rd_o = rat_q[1];
endmodule

// File: rtl/lsg_dwell.sv
// Dwell counter: fires tick_o once every max(rate_i,1) running cycles.
module lsg_dwell #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [RW-1:0] rate_i,
  output logic          tick_o,
  output logic [RW-1:0] cnt_o
);
  localparam int XW = RW + 1;

  logic [RW-1:0] cnt_q, cnt_d;
  logic [XW-1:0] cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + XW'(1);
    tick_o  = run_i && !restart_i && (cnt_inc >= {1'b0, rate_i});
    if (!run_i || restart_i || tick_o) cnt_d = '0;
    else                               cnt_d = cnt_inc[RW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lsg_step.sv
// Next value for one step, clamped to the captured limits.
module lsg_step
  import lsg_pkg::*;
#(
  parameter int FW = 32
) (
  input  dir_e          dir_i,
  input  logic [FW-1:0] cur_i,
  input  logic [FW-1:0] hi_i,
  input  logic [FW-1:0] lo_i,
  input  logic [FW-1:0] up_i,
  input  logic [FW-1:0] dn_i,
  output logic [FW-1:0] nxt_o
);
  localparam int XW = FW + 1;

  logic [XW-1:0] sum, dif;
  logic          over, under;
  logic [FW-1:0] up_v, dn_v;

  always_comb begin
    sum   = {1'b0, cur_i} + {1'b0, up_i};
    over  = sum > {1'b0, hi_i};
    up_v  = over ? hi_i : sum[FW-1:0];
    dif   = {1'b0, cur_i} - {1'b0, dn_i};
    under = dif[FW] || (dif[FW-1:0] < lo_i);
    dn_v  = under ? lo_i : dif[FW-1:0];
    nxt_o = (dir_i == DIR_FALL) ? dn_v : up_v;
  end
endmodule

// File: rtl/lin_sweep_gen.sv
module lin_sweep_gen
  import lsg_pkg::*;
#(
  parameter int FW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sweep_en,
  input  logic          dir_fall,
  input  logic [FW-1:0] ftw_base,
  input  logic [FW-1:0] lim_hi,
  input  logic [FW-1:0] lim_lo,
  input  logic [FW-1:0] step_up,
  input  logic [FW-1:0] step_dn,
  input  logic [RW-1:0] rate_up,
  input  logic [RW-1:0] rate_dn,
  output logic [FW-1:0] ftw_out,
  output logic          at_hi,
  output logic          at_lo
);
  logic          rst_sn;
  logic          act_q, act_d;
  dir_e          dir_q, dir_d;
  logic          dseen_q, dseen_d;
  logic [FW-1:0] cur_q, cur_d;
  logic          cur_en;
  logic          ahi_q, ahi_d, alo_q, alo_d;
  logic          start, dir_chg, run, cfg_load, tick;
  logic [FW-1:0] hi_s, lo_s, up_s, dn_s, step_nxt, hi_nx, lo_nx;
  logic [RW-1:0] ru_s, rd_s, rate_sel, dwell_cnt;

  lsg_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  lsg_cfg_hold #(.FW(FW), .RW(RW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sn),
    .load_i (cfg_load),
    .hi_i   (lim_hi),
    .lo_i   (lim_lo),
    .up_i   (step_up),
    .dn_i   (step_dn),
    .ru_i   (rate_up),
    .rd_i   (rate_dn),
    .hi_o   (hi_s),
    .lo_o   (lo_s),
    .up_o   (up_s),
    .dn_o   (dn_s),
    .ru_o   (ru_s),
    .rd_o   (rd_s)
  );

  lsg_dwell #(.RW(RW)) u_dwell (
    .clk       (clk),
    .rst_n     (rst_sn),
    .run_i     (run),
    .restart_i (dir_chg),
    .rate_i    (rate_sel),
    .tick_o    (tick),
    .cnt_o     (dwell_cnt)
  );

  lsg_step #(.FW(FW)) u_step (
    .dir_i (dir_q),
    .cur_i (cur_q),
    .hi_i  (hi_s),
    .lo_i  (lo_s),
    .up_i  (up_s),
    .dn_i  (dn_s),
    .nxt_o (step_nxt)
  );

  // Next-state logic
  always_comb begin
    start    = sweep_en && !act_q;
    run      = sweep_en && act_q;
    dir_chg  = run && (dir_fall != dseen_q);
    rate_sel = (dir_q == DIR_FALL) ? rd_s : ru_s;
    cfg_load = start || tick;
    act_d    = sweep_en;
    dseen_d  = dir_fall;

    if (!sweep_en || start) dir_d = DIR_RISE;
    else if (dir_chg)       dir_d = dir_e'(dir_fall);
    else                    dir_d = dir_q;

    cur_en = !sweep_en || start || tick;
    if (!sweep_en)  cur_d = ftw_base;
    else if (start) cur_d = lim_lo;
    else if (tick)  cur_d = step_nxt;
    else            cur_d = cur_q;

    hi_nx = cfg_load ? lim_hi : hi_s;
    lo_nx = cfg_load ? lim_lo : lo_s;
    ahi_d = sweep_en && (cur_d == hi_nx);
    alo_d = sweep_en && (cur_d == lo_nx);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      act_q   <= 1'b0;
      dir_q   <= DIR_RISE;
      dseen_q <= 1'b0;
      cur_q   <= '0;
      ahi_q   <= 1'b0;
      alo_q   <= 1'b0;
    end else begin
      act_q   <= act_d;
      dir_q   <= dir_d;
      dseen_q <= dseen_d;
      if (cur_en) cur_q <= cur_d;
      ahi_q   <= ahi_d;
      alo_q   <= alo_d;
    end
  end

  assign ftw_out = cur_q;
  assign at_hi   = ahi_q;
  assign at_lo   = alo_q;
endmodule

// File: rtl/lsg_checker.sv
module lsg_checker
  import lsg_pkg::*;
#(
  parameter int FW = 32,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          sweep_en,
  input logic          dir_fall,
  input logic [FW-1:0] ftw_base,
  input logic [FW-1:0] lim_lo,
  input logic [FW-1:0] ftw_out,
  input logic          at_hi,
  input logic          at_lo,
  input logic          act_q,
  input dir_e          dir_q,
  input logic          dseen_q,
  input logic          tick,
  input logic [RW-1:0] dwell_cnt,
  input logic [RW-1:0] rate_sel,
  input logic [FW-1:0] hi_s,
  input logic [FW-1:0] lo_s
);
  // R2: sweep off passes the base word through, no flags
  a_r2_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_sn)
    !sweep_en |=> (ftw_out == $past(ftw_base)) && !at_hi && !at_lo);

  // R3: start loads the floor, raises the low flag and selects rising
  a_r3_start_at_floor: assert property (@(posedge clk) disable iff (!rst_sn)
    (sweep_en && !act_q) |=> (ftw_out == $past(lim_lo)) && at_lo && (dir_q == DIR_RISE));

  // R4 / R5: value holds between dwell ticks
  a_r4_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_sn)
    (act_q && sweep_en && !tick) |=> $stable(ftw_out));

  // R4 / R5: dwell count stays inside the captured interval
  a_r5_dwell_bounded: assert property (@(posedge clk) disable iff (!rst_sn)
    act_q |-> ((dwell_cnt == '0) || (dwell_cnt < rate_sel)));

  // R6: upper flag only while sitting on the captured ceiling
  a_r6_top_flag_value: assert property (@(posedge clk) disable iff (!rst_sn)
    at_hi |-> (ftw_out == hi_s));

  // R7: lower flag only while sitting on the captured floor
  a_r7_floor_flag_value: assert property (@(posedge clk) disable iff (!rst_sn)
    at_lo |-> (ftw_out == lo_s));

  // R9: direction change restarts the count, takes no step, adopts new direction
  a_r9_dir_restart: assert property (@(posedge clk) disable iff (!rst_sn)
    (act_q && sweep_en && (dir_fall != dseen_q)) |=>
      (dwell_cnt == '0) && $stable(ftw_out) && (dir_q == dir_e'($past(dir_fall))));
endmodule

bind lin_sweep_gen lsg_checker #(.FW(FW), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .sweep_en  (sweep_en),
  .dir_fall  (dir_fall),
  .ftw_base  (ftw_base),
  .lim_lo    (lim_lo),
  .ftw_out   (ftw_out),
  .at_hi     (at_hi),
  .at_lo     (at_lo),
  .act_q     (act_q),
  .dir_q     (dir_q),
  .dseen_q   (dseen_q),
  .tick      (tick),
  .dwell_cnt (dwell_cnt),
  .rate_sel  (rate_sel),
  .hi_s      (hi_s),
  .lo_s      (lo_s)
);

// File: tb/lin_sweep_gen_tb.sv
`timescale 1ns/1ps
module lin_sweep_gen_tb;
  localparam int FW = 8;
  localparam int RW = 3;

  logic          clk, rst_n, en, dir_fall;
  logic [FW-1:0] base, hi, lo, du, dd;
  logic [RW-1:0] ru, rd;
  logic [FW-1:0] ftw_out;
  logic          at_hi, at_lo;

  lin_sweep_gen #(.FW(FW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sweep_en(en), .dir_fall(dir_fall),
    .ftw_base(base), .lim_hi(hi), .lim_lo(lo), .step_up(du), .step_dn(dd),
    .rate_up(ru), .rate_dn(rd), .ftw_out(ftw_out), .at_hi(at_hi), .at_lo(at_lo)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  // Arithmetic reference model built from the requirements
  int m_cur, m_cnt, m_hi, m_lo, m_du, m_dd, m_ru, m_rd, m_r;
  bit m_act, m_dir, m_pdir, m_fh, m_fl;

  task automatic m_cap();
    m_hi = hi; m_lo = lo; m_du = du; m_dd = dd; m_ru = ru; m_rd = rd;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_cnt = 0; m_act = 0; m_dir = 0; m_pdir = 0; m_fh = 0; m_fl = 0;
      m_hi = 0; m_lo = 0; m_du = 0; m_dd = 0; m_ru = 0; m_rd = 0;
    end else begin
      if (!en) begin
        m_cur = base; m_act = 0; m_dir = 0; m_cnt = 0;
      end else if (!m_act) begin
        m_act = 1; m_cur = lo; m_cap(); m_cnt = 0; m_dir = 0;
      end else if (dir_fall != m_pdir) begin
        m_dir = dir_fall; m_cnt = 0;
      end else begin
        m_r = m_dir ? m_rd : m_ru;
        if (m_cnt + 1 >= m_r) begin
          if (!m_dir) m_cur = (m_cur + m_du > m_hi) ? m_hi : m_cur + m_du;
          else        m_cur = (m_cur < m_dd + m_lo) ? m_lo : m_cur - m_dd;
          m_cap();
          m_cnt = 0;
        end else m_cnt++;
      end
      m_pdir = dir_fall;
      m_fh = m_act && (m_cur == m_hi);
      m_fl = m_act && (m_cur == m_lo);
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, int n);
    repeat (n) begin
      @(negedge clk);
      chk({tag, " value"}, ftw_out, m_cur);
      chk({tag, " high flag"}, at_hi, m_fh);
      chk({tag, " low flag"}, at_lo, m_fl);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 0; dir_fall = 0; base = 8'd55;
    hi = 8'd90; lo = 8'd20; du = 8'd3; dd = 8'd5; ru = 3'd2; rd = 3'd1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", ftw_out, 0);
    chk("R1 reset high flag", at_hi, 0);
    chk("R1 reset low flag", at_lo, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2: disabled, configuration and direction have no effect
    base = 8'd123; hi = 8'd7; lo = 8'd200; dir_fall = 1;
    @(negedge clk);
    chk("R2 passthrough", ftw_out, 123);
    chk("R2 no high flag", at_hi, 0);
    chk("R2 no low flag", at_lo, 0);
    dir_fall = 0; du = 8'd99; ru = 3'd0;
    cyc("R2 idle", 4);

    // R3 R4 R5 R6 R7: sweep over rates and step sizes
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 3; k++) begin
        lo = 8'd20; hi = 8'd90;
        du = (k == 0) ? 8'd1 : (k == 1) ? 8'd4 : 8'd9;
        dd = du + 8'd2;
        ru = RW'(r); rd = RW'((r + 1) % 4);
        dir_fall = 0; en = 1;
        @(negedge clk);
        chk("R3 start value", ftw_out, 20);
        chk("R3 start low flag", at_lo, 1);
        cyc("R4 R6 rising", 60);
        dir_fall = 1;
        cyc("R5 R7 falling", 60);
        en = 0;
        cyc("R2 disable", 2);
      end
    end

    // R8: zero rate steps on every clock
    lo = 8'd20; hi = 8'd90; du = 8'd3; ru = 3'd0; dir_fall = 0; en = 1;
    @(negedge clk); chk("R8 start", ftw_out, 20);
    @(negedge clk); chk("R8 first step", ftw_out, 23);
    @(negedge clk); chk("R8 second step", ftw_out, 26);
    en = 0;
    cyc("R2 disable", 2);

    // R6 / R7: clamps across carry and borrow
    lo = 8'd5; hi = 8'd250; du = 8'd40; dd = 8'd40; ru = 3'd1; rd = 3'd2; en = 1;
    cyc("R6 wide rise", 10);
    chk("R6 clamp at ceiling", ftw_out, 250);
    chk("R6 ceiling flag", at_hi, 1);
    dir_fall = 1;
    cyc("R7 wide fall", 18);
    chk("R7 clamp at floor", ftw_out, 5);
    chk("R7 floor flag", at_lo, 1);
    en = 0; dir_fall = 0;
    cyc("R2 disable", 2);

    // R9: direction changes in mid-interval
    lo = 8'd0; hi = 8'd255; du = 8'd2; dd = 8'd1; ru = 3'd5; rd = 3'd3; en = 1;
    for (int i = 0; i < 60; i++) begin
      dir_fall = rnd() % 2;
      cyc("R9 direction", 1 + rnd() % 6);
    end
    en = 0;
    cyc("R2 disable", 2);

    // R10: configuration rewritten at arbitrary times
    lo = 8'd30; hi = 8'd200; du = 8'd7; dd = 8'd6; ru = 3'd3; rd = 3'd4; en = 1; dir_fall = 0;
    for (int i = 0; i < 120; i++) begin
      case (rnd() % 7)
        0: lo = 8'(rnd() % 60);
        1: hi = 8'(150 + rnd() % 106);
        2: du = 8'(rnd() % 32);
        3: dd = 8'(rnd() % 32);
        4: ru = RW'(rnd());
        5: rd = RW'(rnd());
        default: dir_fall = ~dir_fall;
      endcase
      cyc("R10 live update", 1 + rnd() % 5);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule